// File: doc/BRIEF.md
# Register File with Rename Tags

This block holds the architectural integer registers of an out-of-order core. Each register also carries a rename tag and a ready flag. The tag is the reorder-buffer slot of the newest in-flight instruction that will write the register. The ready flag says that no such instruction is outstanding.

An issue cycle can look up two source operands. For each source, one cycle later, the block presents the value, the producer tag and the ready flag. In the same issue cycle it can claim a destination register for the instruction being issued. A commit writes the retired value into its register. The commit frees the register only if the register's tag still names the committing instruction, so an older commit never releases a register that a younger instruction has since claimed.

Register 0 always reads as a ready zero. The issue and commit paths are plain strobes with no back-pressure: the block accepts every issue and every commit in the cycle it is presented. Source results are registered, and they hold their last value until that source is looked up again.

Top module: `rf_rename_top`

## Requirements
- R1: After reset every register holds value 0, tag 0 and ready 1, and both source outputs read value 0, tag 0, ready 1.
- R2: A source lookup of index 0 returns value 0, tag 0 and ready 1, whatever has been issued or committed to index 0.
- R3: A source lookup of a nonzero index that equals a same-cycle commit index returns the commit value, tag 0 and ready 1.
- R4: Any other lookup returns the stored value, tag and ready flag of the requested register, on the outputs after the clock edge that samples the issue.
- R5: An issue with has_rd set and a nonzero rd_idx sets that register's tag to issue_tag and clears its ready flag.
- R6: A source's outputs change only on an edge where issue_valid and that source's has_rs bit are both 1; otherwise they hold.
- R7: Issues and commits aimed at index 0 change no state.
- R8: A commit to a nonzero index always writes the value. It sets ready only when the register's stored tag equals commit_tag.
- R9: When an issue claims the same register that is being committed in the same cycle, the claim wins: the new tag is stored, ready is 0, and the value becomes the commit value.
- R10: A source lookup of the same register that the same issue claims as its destination returns the state from before the claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| has_rs1 | input | 1 | Issued instruction uses source 1 |
| rs1_idx | input | IDX_W | Source 1 register index |
| has_rs2 | input | 1 | Issued instruction uses source 2 |
| rs2_idx | input | IDX_W | Source 2 register index |
| has_rd | input | 1 | Issued instruction writes a destination |
| rd_idx | input | IDX_W | Destination register index |
| issue_tag | input | TAG_W | Reorder-buffer slot of the issuing instruction |
| commit_valid | input | 1 | An instruction retires this cycle |
| commit_idx | input | IDX_W | Retiring destination index |
| commit_tag | input | TAG_W | Reorder-buffer slot of the retiring instruction |
| commit_value | input | XLEN | Retired result |
| rs1_value | output | XLEN | Source 1 value |
| rs1_tag | output | TAG_W | Source 1 producer tag |
| rs1_ready | output | 1 | Source 1 has no pending producer |
| rs2_value | output | XLEN | Source 2 value |
| rs2_tag | output | TAG_W | Source 2 producer tag |
| rs2_ready | output | 1 | Source 2 has no pending producer |

## Verification
Issue and commit can land in the same cycle, and two overlaps between them matter. In the first, a source lookup hits the register being committed. The bench shows that the lookup forwards the commit value as ready with tag 0. In the second, the destination claim and the commit name the same register. The bench drives both strobes in a single cycle and then reads the register back on a later issue: it must show the new tag, ready 0 and the committed value. The stale-commit case is also checked: a commit whose tag is older than the register's current tag must write the value and leave ready at 0.

// File: rtl/rf_rename_pkg.sv
package rf_rename_pkg;
  localparam int DEF_NUM_REGS = 32;
  localparam int DEF_XLEN     = 32;
  localparam int DEF_TAG_W    = 5;

  // where a source lookup takes its result from
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_STORE  = 2'd2
  } src_sel_e;
endpackage

// File: rtl/rf_slot.sv
module rf_slot #(
  parameter int XLEN  = 32,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             claim,
  input  logic [TAG_W-1:0] claim_tag,
  input  logic             wr,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [XLEN-1:0]  wr_value,
  output logic [XLEN-1:0]  val,
  output logic [TAG_W-1:0] tag,
  output logic             rdy
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
      tag <= '0;
      rdy <= 1'b1;
    end else begin
      if (wr) val <= wr_value;
      // a fresh claim outranks the release by a commit
      if (claim) begin
        tag <= claim_tag;
        rdy <= 1'b0;
      end else if (wr && (tag == wr_tag)) begin
        rdy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_rename_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int XLEN     = 32,
  parameter int TAG_W    = 5,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  slot_val [NUM_REGS],
  input  logic [TAG_W-1:0] slot_tag [NUM_REGS],
  input  logic             slot_rdy [NUM_REGS],
  input  logic             commit_valid,
  input  logic [IDX_W-1:0] commit_idx,
  input  logic [XLEN-1:0]  commit_value,
  output logic [XLEN-1:0]  out_val,
  output logic [TAG_W-1:0] out_tag,
  output logic             out_rdy
);
  src_sel_e sel;

  always_comb begin
    if (idx == '0)                               sel = SRC_ZERO;
    else if (commit_valid && commit_idx == idx)  sel = SRC_BYPASS;
    else                                         sel = SRC_STORE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_val <= '0;
      out_tag <= '0;
      out_rdy <= 1'b1;
    end else if (rd_en) begin
      case (sel)
        SRC_ZERO: begin
          out_val <= '0;
          out_tag <= '0;
          out_rdy <= 1'b1;
        end
        SRC_BYPASS: begin
          out_val <= commit_value;
          out_tag <= '0;
          out_rdy <= 1'b1;
        end
        default: begin
          out_val <= slot_val[idx];
          out_tag <= slot_tag[idx];
          out_rdy <= slot_rdy[idx];
        end
      endcase
    end
  end
endmodule

// File: rtl/rf_rename_top.sv
module rf_rename_top
  import rf_rename_pkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int XLEN     = DEF_XLEN,
  parameter int TAG_W    = DEF_TAG_W,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic             has_rs1,
  input  logic [IDX_W-1:0] rs1_idx,
  input  logic             has_rs2,
  input  logic [IDX_W-1:0] rs2_idx,
  input  logic             has_rd,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] issue_tag,
  input  logic             commit_valid,
  input  logic [IDX_W-1:0] commit_idx,
  input  logic [TAG_W-1:0] commit_tag,
  input  logic [XLEN-1:0]  commit_value,
  output logic [XLEN-1:0]  rs1_value,
  output logic [TAG_W-1:0] rs1_tag,
  output logic             rs1_ready,
  output logic [XLEN-1:0]  rs2_value,
  output logic [TAG_W-1:0] rs2_tag,
  output logic             rs2_ready
);
  localparam int NUM_SRC = 2;

  logic [XLEN-1:0]  slot_val [NUM_REGS];
  logic [TAG_W-1:0] slot_tag [NUM_REGS];
  logic             slot_rdy [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    if (g == 0) begin : g_zero
      assign slot_val[g] = '0;
      assign slot_tag[g] = '0;
      assign slot_rdy[g] = 1'b1;
    end else begin : g_live
      logic claim, wr;
      assign claim = issue_valid && has_rd && (rd_idx == IDX_W'(g));
      assign wr    = commit_valid && (commit_idx == IDX_W'(g));
      rf_slot #(.XLEN(XLEN), .TAG_W(TAG_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .claim    (claim),
        .claim_tag(issue_tag),
        .wr       (wr),
        .wr_tag   (commit_tag),
        .wr_value (commit_value),
        .val      (slot_val[g]),
        .tag      (slot_tag[g]),
        .rdy      (slot_rdy[g])
      );
    end
  end

  logic             src_en  [NUM_SRC];
  logic [IDX_W-1:0] src_idx [NUM_SRC];
  logic [XLEN-1:0]  src_val [NUM_SRC];
  logic [TAG_W-1:0] src_tag [NUM_SRC];
  logic             src_rdy [NUM_SRC];

  assign src_en[0]  = issue_valid && has_rs1;
  assign src_en[1]  = issue_valid && has_rs2;
  assign src_idx[0] = rs1_idx;
  assign src_idx[1] = rs2_idx;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rf_read_port #(
      .NUM_REGS(NUM_REGS), .XLEN(XLEN), .TAG_W(TAG_W), .IDX_W(IDX_W)
    ) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_en       (src_en[s]),
      .idx         (src_idx[s]),
      .slot_val    (slot_val),
      .slot_tag    (slot_tag),
      .slot_rdy    (slot_rdy),
      .commit_valid(commit_valid),
      .commit_idx  (commit_idx),
      .commit_value(commit_value),
      .out_val     (src_val[s]),
      .out_tag     (src_tag[s]),
      .out_rdy     (src_rdy[s])
    );
  end

  assign rs1_value = src_val[0];
  assign rs1_tag   = src_tag[0];
  assign rs1_ready = src_rdy[0];
  assign rs2_value = src_val[1];
  assign rs2_tag   = src_tag[1];
  assign rs2_ready = src_rdy[1];
endmodule

// File: rtl/rf_rename_chk.sv
module rf_rename_chk #(
  parameter int XLEN  = 32,
  parameter int TAG_W = 5,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_valid,
  input logic             has_rs1,
  input logic [IDX_W-1:0] rs1_idx,
  input logic             has_rs2,
  input logic [IDX_W-1:0] rs2_idx,
  input logic             commit_valid,
  input logic [IDX_W-1:0] commit_idx,
  input logic [XLEN-1:0]  commit_value,
  input logic [XLEN-1:0]  rs1_value,
  input logic [TAG_W-1:0] rs1_tag,
  input logic             rs1_ready,
  input logic [XLEN-1:0]  rs2_value,
  input logic [TAG_W-1:0] rs2_tag,
  input logic             rs2_ready
);
  p_x0_rs1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && has_rs1 && rs1_idx == '0) |=>
      (rs1_ready && rs1_value == '0 && rs1_tag == '0));

  p_x0_rs2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && has_rs2 && rs2_idx == '0) |=>
      (rs2_ready && rs2_value == '0 && rs2_tag == '0));

  p_bypass_rs1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && has_rs1 && rs1_idx != '0 && commit_valid && commit_idx == rs1_idx) |=>
      (rs1_ready && rs1_tag == '0 && rs1_value == $past(commit_value)));

  p_bypass_rs2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && has_rs2 && rs2_idx != '0 && commit_valid && commit_idx == rs2_idx) |=>
      (rs2_ready && rs2_tag == '0 && rs2_value == $past(commit_value)));

  p_hold_rs1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_valid && has_rs1) |=>
      ($stable(rs1_value) && $stable(rs1_tag) && $stable(rs1_ready)));

  p_hold_rs2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_valid && has_rs2) |=>
      ($stable(rs2_value) && $stable(rs2_tag) && $stable(rs2_ready)));
endmodule

bind rf_rename_top rf_rename_chk #(.XLEN(XLEN), .TAG_W(TAG_W), .IDX_W(IDX_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .has_rs1     (has_rs1),
  .rs1_idx     (rs1_idx),
  .has_rs2     (has_rs2),
  .rs2_idx     (rs2_idx),
  .commit_valid(commit_valid),
  .commit_idx  (commit_idx),
  .commit_value(commit_value),
  .rs1_value   (rs1_value),
  .rs1_tag     (rs1_tag),
  .rs1_ready   (rs1_ready),
  .rs2_value   (rs2_value),
  .rs2_tag     (rs2_tag),
  .rs2_ready   (rs2_ready)
);

// File: tb/test_rf_rename_top.sv
module test_rf_rename_top;
  localparam int XLEN  = 32;
  localparam int TAG_W = 5;
  localparam int IDX_W = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             issue_valid, has_rs1, has_rs2, has_rd;
  logic [IDX_W-1:0] rs1_idx, rs2_idx, rd_idx;
  logic [TAG_W-1:0] issue_tag;
  logic             commit_valid;
  logic [IDX_W-1:0] commit_idx;
  logic [TAG_W-1:0] commit_tag;
  logic [XLEN-1:0]  commit_value;
  logic [XLEN-1:0]  rs1_value, rs2_value;
  logic [TAG_W-1:0] rs1_tag, rs2_tag;
  logic             rs1_ready, rs2_ready;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  rf_rename_top i_rf_rename_top (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .has_rs1(has_rs1), .rs1_idx(rs1_idx),
    .has_rs2(has_rs2), .rs2_idx(rs2_idx), .has_rd(has_rd), .rd_idx(rd_idx),
    .issue_tag(issue_tag), .commit_valid(commit_valid), .commit_idx(commit_idx),
    .commit_tag(commit_tag), .commit_value(commit_value),
    .rs1_value(rs1_value), .rs1_tag(rs1_tag), .rs1_ready(rs1_ready),
    .rs2_value(rs2_value), .rs2_tag(rs2_tag), .rs2_ready(rs2_ready)
  );

  task automatic clear_inputs();
    issue_valid = 0; has_rs1 = 0; has_rs2 = 0; has_rd = 0;
    rs1_idx = '0; rs2_idx = '0; rd_idx = '0; issue_tag = '0;
    commit_valid = 0; commit_idx = '0; commit_tag = '0; commit_value = '0;
  endtask

  // one edge, then sample and drive 1 ns later
  task automatic step();
    @(posedge clk);
    #1;
    clear_inputs();
  endtask

  task automatic check(string req, string what, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic set_issue(bit h1, int i1, bit h2, int i2, bit hd, int d, int t);
    issue_valid = 1; has_rs1 = h1; rs1_idx = IDX_W'(i1);
    has_rs2 = h2; rs2_idx = IDX_W'(i2); has_rd = hd; rd_idx = IDX_W'(d);
    issue_tag = TAG_W'(t);
  endtask

  task automatic set_commit(int idx, int t, logic [XLEN-1:0] v);
    commit_valid = 1; commit_idx = IDX_W'(idx); commit_tag = TAG_W'(t); commit_value = v;
  endtask

  task automatic expect_rs1(string req, logic [XLEN-1:0] v, int t, bit r);
    check(req, "rs1_value", rs1_value, v);
    check(req, "rs1_tag", XLEN'(rs1_tag), XLEN'(t));
    check(req, "rs1_ready", XLEN'(rs1_ready), XLEN'(r));
  endtask

  task automatic expect_rs2(string req, logic [XLEN-1:0] v, int t, bit r);
    check(req, "rs2_value", rs2_value, v);
    check(req, "rs2_tag", XLEN'(rs2_tag), XLEN'(t));
    check(req, "rs2_ready", XLEN'(rs2_ready), XLEN'(r));
  endtask

  task automatic read_both(int i1, int i2);
    set_issue(1, i1, 1, i2, 0, 0, 0);
    step();
  endtask

  task automatic t_reset();   // R1
    expect_rs1("R1", '0, 0, 1);
    expect_rs2("R1", '0, 0, 1);
    read_both(5, 31);
    expect_rs1("R1", '0, 0, 1);
    expect_rs2("R1", '0, 0, 1);
  endtask

  task automatic t_zero();    // R2, R7
    set_issue(0, 0, 0, 0, 1, 0, 7); step();
    set_commit(0, 0, 32'hDEAD_BEEF); step();
    read_both(0, 0);
    expect_rs1("R2", '0, 0, 1);
    expect_rs2("R7", '0, 0, 1);
  endtask

  task automatic t_rename_commit();   // R5, R8, R4
    set_issue(0, 0, 0, 0, 1, 3, 9); step();
    read_both(3, 1);
    expect_rs1("R5", '0, 9, 0);
    expect_rs2("R4", '0, 0, 1);
    set_commit(3, 9, 32'h0000_1234); step();
    read_both(2, 3);
    expect_rs2("R8", 32'h0000_1234, 9, 1);
  endtask

  task automatic t_stale_commit();    // R8
    set_issue(0, 0, 0, 0, 1, 4, 2); step();
    set_issue(0, 0, 0, 0, 1, 4, 5); step();
    set_commit(4, 2, 32'h0000_00AA); step();
    read_both(4, 4);
    expect_rs1("R8", 32'h0000_00AA, 5, 0);
    set_commit(4, 5, 32'h0000_00BB); step();
    read_both(4, 0);
    expect_rs1("R8", 32'h0000_00BB, 5, 1);
  endtask

  task automatic t_bypass();  // R3
    set_issue(0, 0, 0, 0, 1, 6, 1); step();
    set_issue(1, 6, 1, 7, 0, 0, 0);
    set_commit(6, 1, 32'h0000_0077);
    step();
    expect_rs1("R3", 32'h0000_0077, 0, 1);
    expect_rs2("R4", '0, 0, 1);
  endtask

  task automatic t_hold();    // R6
    read_both(3, 4);
    set_issue(0, 0, 1, 6, 0, 0, 0); step();
    expect_rs1("R6", 32'h0000_1234, 9, 1);
    expect_rs2("R6", 32'h0000_0077, 1, 1);
    has_rs1 = 1; rs1_idx = 5'd4; has_rs2 = 1; rs2_idx = 5'd3;
    step();
    expect_rs1("R6", 32'h0000_1234, 9, 1);
    expect_rs2("R6", 32'h0000_0077, 1, 1);
  endtask

  task automatic t_claim_vs_commit();  // R9
    set_issue(0, 0, 0, 0, 1, 8, 3); step();
    set_issue(0, 0, 0, 0, 1, 8, 4);
    set_commit(8, 3, 32'h0000_0055);
    step();
    read_both(8, 0);
    expect_rs1("R9", 32'h0000_0055, 4, 0);
  endtask

  task automatic t_self_read();   // R10
    set_commit(10, 0, 32'h0000_0099); step();
    set_issue(1, 10, 0, 0, 1, 10, 12); step();
    expect_rs1("R10", 32'h0000_0099, 0, 1);
    read_both(10, 10);
    expect_rs2("R10", 32'h0000_0099, 12, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_zero();
    t_rename_commit();
    t_stale_commit();
    t_bypass();
    t_hold();
    t_claim_vs_commit();
    t_self_read();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule